// File: doc/BRIEF.md
# Dual-NLFSR 64-bit Block Encryption Core

The core encrypts one 64-bit block under an 80-bit key. The block is held in two nonlinear feedback shift registers: an upper register of 25 bits and a lower register of 39 bits. Each clock cycle performs one round. In that round, two nonlinear feedback functions are each evaluated three times in parallel, and both registers move three positions toward their MSB. The output of each function feeds the least significant end of the other register.

The two round-key bits come from an 80-bit key LFSR, which advances two positions per round. An 8-bit LFSR supplies an irregular-update bit that gates one product term of the upper-register function.

A caller presents the plaintext and the key with a one-cycle `start_i`. It then waits for the one-cycle `done_o` pulse, which comes 254 cycles after the start was accepted. The ciphertext stays on `cipher_o` until the next accepted start.

Top module: `nlfsr64_enc`

## Requirements
- R1: On an accepted start, plaintext bits 63..39 load the upper register U (U[24:0]) and bits 38..0 load the lower register W (W[38:0]). `cipher_o` always shows {U, W} in the same arrangement.
- R2: A single update computes fa = U[24]^U[15]^(U[20]&U[11])^(U[9]&ir)^ka and fb = W[38]^W[25]^(W[33]&W[21])^(W[14]&W[9])^kb. Both registers then shift one place toward the MSB, U[0] takes fb and W[0] takes fa.
- R3: A round applies the R2 update three times in succession, all with the same ka, kb and ir. All three applications fit into one clock cycle.
- R4: On an accepted start, key bit n loads key-register position n. Each round takes ka from position 0 and kb from position 1. The key register then advances two positions toward position 0, and each new top bit is r[0]^r[19]^r[30]^r[67] of the register as it stands at that step.
- R5: The irregular-update register s[7:0] is set to 8'hFF on an accepted start. Each round uses ir = s[7] and then steps to {s[6:0], s[7]^s[6]^s[4]^s[2]}.
- R6: One accepted start runs exactly 254 rounds, one per cycle. `busy_o` is high from the cycle after acceptance through the last round. `done_o` is high for exactly one cycle, 254 clock edges after the accepting edge, with `busy_o` low.
- R7: A start raised while `busy_o` is high is ignored: the running encryption and its result are unaffected.
- R8: After reset `busy_o` and `done_o` are low. While idle with no start, `cipher_o` holds its value.
- R9: A start presented in the cycle where `done_o` is high is accepted, because `busy_o` is already low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an encryption when idle |
| plain_i | input | 64 | Plaintext block |
| key_i | input | 80 | Cipher key |
| busy_o | output | 1 | Rounds in progress |
| done_o | output | 1 | One-cycle pulse when the ciphertext is ready |
| cipher_o | output | 64 | Ciphertext, {U, W} |

## Verification
The bench compares every result against a model that builds the round-key bit stream from the linear recurrence and performs the 762 single updates one at a time. Any error in tap selection, triad offset, the crossing of outputs between registers or key-register direction therefore corrupts the ciphertext.

The bench uses all-zero and all-one blocks and keys, where a missing irregular-update gate or a swapped feedback would still show. It injects a competing start in the middle of a run; a core that reloaded on that start would return the second block's ciphertext. It also issues a start in the done cycle; a core that kept busy high one cycle too long would drop that request or stretch the latency past 254.

// File: rtl/nlfsr64_pkg.sv
package nlfsr64_pkg;
  localparam int BLK_W   = 64;
  localparam int U_W     = 25;
  localparam int W_W     = BLK_W - U_W;
  localparam int KEY_W   = 80;
  localparam int ROUNDS  = 254;
  localparam int STEPS   = 3;
  localparam int KEY_ADV = 2;
  // upper-register function taps
  localparam int UA_X0 = 24, UA_X1 = 15, UA_P0 = 20, UA_P1 = 11, UA_IR = 9;
  // lower-register function taps
  localparam int WB_X0 = 38, WB_X1 = 25, WB_P0 = 33, WB_P1 = 21, WB_Q0 = 14, WB_Q1 = 9;
  // key recurrence exponents x^80 + x^61 + x^50 + x^13 + 1
  localparam int KP_A = 61, KP_B = 50, KP_C = 13;
  // irregular-update LFSR x^8 + x^7 + x^5 + x^3 + 1
  localparam int IR_W = 8;
  localparam int IP_A = 7, IP_B = 5, IP_C = 3;
endpackage

// File: rtl/nlfsr64_round.sv
module nlfsr64_round
  import nlfsr64_pkg::*;
#(
  parameter int NSTEP = STEPS
) (
  input  logic [U_W-1:0] u_i,
  input  logic [W_W-1:0] w_i,
  input  logic           ka_i,
  input  logic           kb_i,
  input  logic           ir_i,
  output logic [U_W-1:0] u_o,
  output logic [W_W-1:0] w_o
);
  logic [NSTEP-1:0] fa, fb;

  // step j reads the taps j places lower; step 0 lands highest
  for (genvar j = 0; j < NSTEP; j++) begin : g_step
    assign fa[NSTEP-1-j] = u_i[UA_X0-j] ^ u_i[UA_X1-j]
                         ^ (u_i[UA_P0-j] & u_i[UA_P1-j])
                         ^ (u_i[UA_IR-j] & ir_i) ^ ka_i;
    assign fb[NSTEP-1-j] = w_i[WB_X0-j] ^ w_i[WB_X1-j]
                         ^ (w_i[WB_P0-j] & w_i[WB_P1-j])
                         ^ (w_i[WB_Q0-j] & w_i[WB_Q1-j]) ^ kb_i;
  end

  assign u_o = {u_i[U_W-1-NSTEP:0], fb};
  assign w_o = {w_i[W_W-1-NSTEP:0], fa};
endmodule

// File: rtl/nlfsr64_keyreg.sv
module nlfsr64_keyreg
  import nlfsr64_pkg::*;
#(
  parameter int KW  = KEY_W,
  parameter int ADV = KEY_ADV
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic [KW-1:0] key_i,
  output logic [KW-1:0] st_o
);
  localparam int OFF_A = KW - KP_A;
  localparam int OFF_B = KW - KP_B;
  localparam int OFF_C = KW - KP_C;

  logic [KW-1:0]  st_q, st_nxt;
  logic [ADV-1:0] fbk;

  for (genvar j = 0; j < ADV; j++) begin : g_fb
    assign fbk[j] = st_q[j] ^ st_q[j+OFF_A] ^ st_q[j+OFF_B] ^ st_q[j+OFF_C];
  end

  assign st_nxt = {fbk, st_q[KW-1:ADV]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= '0;
    else if (load_i) st_q <= key_i;
    else if (adv_i)  st_q <= st_nxt;
  end

  assign st_o = st_q;
endmodule

// File: rtl/nlfsr64_irgen.sv
module nlfsr64_irgen
  import nlfsr64_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            adv_i,
  output logic [IR_W-1:0] st_o
);
  logic [IR_W-1:0] st_q;
  logic            fbk;

  assign fbk = st_q[IR_W-1] ^ st_q[IP_A-1] ^ st_q[IP_B-1] ^ st_q[IP_C-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= '0;
    else if (load_i) st_q <= '1;
    else if (adv_i)  st_q <= {st_q[IR_W-2:0], fbk};
  end

  assign st_o = st_q;
endmodule

// File: rtl/nlfsr64_enc.sv
module nlfsr64_enc
  import nlfsr64_pkg::*;
#(
  parameter int NROUND = ROUNDS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BLK_W-1:0] plain_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [BLK_W-1:0] cipher_o
);
  localparam int CNT_W = $clog2(NROUND);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NROUND - 1);

  logic [U_W-1:0]   u_q, u_nxt;
  logic [W_W-1:0]   w_q, w_nxt;
  logic [CNT_W-1:0] rnd_q;
  logic             busy_q, done_q;
  logic             accept;
  logic [KEY_W-1:0] key_st;
  logic [IR_W-1:0]  ir_st;

  assign accept = start_i & ~busy_q;

  nlfsr64_keyreg u_key (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .adv_i (busy_q),
    .key_i (key_i),
    .st_o  (key_st)
  );

  nlfsr64_irgen u_ir (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .adv_i (busy_q),
    .st_o  (ir_st)
  );

  nlfsr64_round #(.NSTEP(STEPS)) u_rnd (
    .u_i (u_q),
    .w_i (w_q),
    .ka_i(key_st[0]),
    .kb_i(key_st[1]),
    .ir_i(ir_st[IR_W-1]),
    .u_o (u_nxt),
    .w_o (w_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      u_q    <= '0;
      w_q    <= '0;
      rnd_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        u_q    <= plain_i[BLK_W-1:W_W];
        w_q    <= plain_i[W_W-1:0];
        rnd_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        u_q   <= u_nxt;
        w_q   <= w_nxt;
        rnd_q <= rnd_q + 1'b1;
        if (rnd_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign cipher_o = {u_q, w_q};
endmodule

// File: rtl/nlfsr64_enc_chk.sv
module nlfsr64_enc_chk
  import nlfsr64_pkg::*;
#(
  parameter int NROUND = ROUNDS,
  parameter int CNT_W  = $clog2(NROUND)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [KEY_W-1:0] key_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [BLK_W-1:0] cipher_o,
  input logic [CNT_W-1:0] rnd_q,
  input logic [KEY_W-1:0] key_st,
  input logic [IR_W-1:0]  ir_st
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NROUND - 1);

  always @(posedge clk_i)
    if (!rst_ni) AST_RESET_IDLE: assert (!busy_o && !done_o); // R8

  AST_KEY_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> key_st == $past(key_i)); // R4
  AST_KEY_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> key_st[KEY_W-3:0] == $past(key_st[KEY_W-1:2])); // R4
  AST_IR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> ir_st == '1); // R5
  AST_ROUND_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && rnd_q != LAST |=> busy_o && !done_o && rnd_q == CNT_W'($past(rnd_q) + 1'b1)); // R6
  AST_LAST_ROUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && rnd_q == LAST |=> done_o && !busy_o); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !done_o && !busy_o); // R6
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && rnd_q != LAST |=> busy_o && rnd_q != '0); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(cipher_o) && !busy_o); // R8
  AST_DONE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && start_i |=> busy_o && rnd_q == '0); // R9
endmodule

bind nlfsr64_enc nlfsr64_enc_chk #(.NROUND(NROUND), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .key_i   (key_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .cipher_o(cipher_o),
  .rnd_q   (rnd_q),
  .key_st  (key_st),
  .ir_st   (ir_st)
);

// File: tb/tb_nlfsr64_enc.sv
`timescale 1ns/1ps
module tb_nlfsr64_enc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] plain_i = '0;
  logic [79:0] key_i = '0;
  logic        busy_o, done_o;
  logic [63:0] cipher_o;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;

  always #2.5 clk_i = ~clk_i;

  nlfsr64_enc dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .plain_i(plain_i), .key_i(key_i),
    .busy_o(busy_o), .done_o(done_o), .cipher_o(cipher_o)
  );

  // bit-serial model: one update at a time, key bits from the recurrence
  function automatic logic [63:0] ref_enc(input logic [63:0] p, input logic [79:0] k);
    logic [24:0]  u;
    logic [38:0]  w;
    logic [507:0] ks;
    logic [7:0]   s;
    logic         ir, ka, kb, fa, fb;
    ks[79:0] = k;
    for (int i = 80; i < 508; i++) ks[i] = ks[i-80] ^ ks[i-61] ^ ks[i-50] ^ ks[i-13];
    u = p[63:39];
    w = p[38:0];
    s = 8'hFF;
    for (int r = 0; r < 254; r++) begin
      ir = s[7];
      ka = ks[2*r];
      kb = ks[2*r+1];
      for (int t = 0; t < 3; t++) begin
        fa = u[24] ^ u[15] ^ (u[20] & u[11]) ^ (u[9] & ir) ^ ka;
        fb = w[38] ^ w[25] ^ (w[33] & w[21]) ^ (w[14] & w[9]) ^ kb;
        u = {u[23:0], fb};
        w = {w[37:0], fa};
      end
      s = {s[6:0], s[7] ^ s[6] ^ s[4] ^ s[2]};
    end
    return {u, w};
  endfunction

  task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // caller stands just after a negedge; returns at the negedge where done is seen
  task automatic run(input logic [63:0] p, input logic [79:0] k, input bit glitch);
    int unsigned cnt;
    logic [63:0] exp;
    exp = ref_enc(p, k);
    start_i = 1'b1; plain_i = p; key_i = k;
    @(negedge clk_i);
    start_i = 1'b0;
    cnt = 0;
    check(busy_o == 1'b1, "R6 busy after accept", 80'(busy_o), 80'd1);
    while (!done_o && cnt < 1000) begin
      if (glitch && cnt == 100) begin
        start_i = 1'b1; plain_i = ~p; key_i = ~k;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
      cnt++;
    end
    start_i = 1'b0;
    check(cnt == 254, "R6 latency", 80'(cnt), 80'd254);
    check(!busy_o, "R6 busy low at done", 80'(busy_o), 80'd0);
    if (glitch) check(cipher_o == exp, "R7 start ignored while busy", 80'(cipher_o), 80'(exp));
    else        check(cipher_o == exp, "R1 R2 R3 R4 R5 ciphertext", 80'(cipher_o), 80'(exp));
  endtask

  task automatic after_done();
    logic [63:0] held;
    held = cipher_o;
    @(negedge clk_i);
    check(!done_o, "R6 done one cycle", 80'(done_o), 80'd0);
    repeat (4) @(negedge clk_i);
    check(cipher_o == held && !busy_o, "R8 idle hold", 80'(cipher_o), 80'(held));
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    logic [63:0] p;
    logic [79:0] k;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o, "R8 reset idle", 80'({busy_o, done_o}), 80'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !done_o && cipher_o == '0, "R8 after reset", 80'(cipher_o), 80'd0);

    run(64'h0, 80'h0, 1'b0);                 after_done();
    run('1, '1, 1'b0);                        after_done();
    run(64'h8000_0000_0000_0001, 80'h1, 1'b0); after_done();
    for (int i = 0; i < 6; i++) begin
      p = {$urandom, $urandom};
      k = {16'($urandom), $urandom, $urandom};
      run(p, k, 1'b0); after_done();
    end
    // R7: competing start mid-run
    run(64'h0123_4567_89AB_CDEF, 80'hFEDC_BA98_7654_3210_0F0F, 1'b1); after_done();
    // R9: new start in the done cycle
    run(64'hDEAD_BEEF_0000_1111, 80'h1234_5678_9ABC_DEF0_5555, 1'b0);
    check(done_o && !busy_o, "R9 done cycle idle", 80'({done_o, busy_o}), 80'h2);
    run(64'h0F1E_2D3C_4B5A_6978, 80'hA5A5_5A5A_0000_FFFF_1234, 1'b0); after_done();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule